// File: doc/BRIEF.md
# Biphase Frame Transmit Serializer

This block turns host writes into serial frames on a single biphase line. The host first sets a small control register holding a 3-bit station address and a parity-sense select. Each later write of a data byte joins that byte with the current control fields into a 12-bit word, which goes into a 4-word transmit FIFO. A write into an empty, idle block starts transmission by itself.

For every word, the serializer sends a fixed sync pattern and then a 16-bit frame. The frame holds a start bit, the data byte, the address, a parity bit and three zero fill bits. Between frames of one message it can add a programmable run of extra zero fill bits. The fill register holds the one's complement of that count. When no word is waiting at the end of a frame, the line returns to idle after the three fill bits. An input can invert the line polarity, idle level included. One bit cell lasts `2*HALF_CLKS` clocks. At a 1 MHz bit rate this is 1 µs.

Top module: `biph_frame_tx`

## Requirements
- R1: After reset the block is idle (`tx_busy`=0), the FIFO is empty (`fifo_empty`=1, `fifo_full`=0), `fifo_ovf` is 0, `tx_line` equals `tx_inv`, and the fill register holds 0xFF, so no extra fill is sent until it is rewritten.
- R2: A data write stores {parity select, address, data} using the control register value held before that cycle. A control write in the same cycle applies only to later data writes.
- R3: Each frame goes out as the sync pattern 1,1,1,0. It is followed by a start bit of 1, data bits 0 to 7, address bits 0 to 2 (`ctl_wdata[2:0]`), the parity bit, and three 0 fill bits, for 16 bits after sync.
- R4: The parity bit is the XOR of the start bit, the 8 data bits and the 3 address bits, XORed with the parity select (`ctl_wdata[3]`): 0 gives even parity over those 13 bits, 1 gives odd.
- R5: Each bit cell has two halves of `HALF_CLKS` clocks. Before inversion, the first half carries the complement of the bit and the second half carries the bit, so every cell has a mid-cell transition.
- R6: With `tx_inv`=1 the line is the complement of the uninverted line, the idle level included.
- R7: When a word is waiting at the end of a frame's fill bits, `~fill` (8 bits) extra 0 cells are sent before the next sync. A fill value of 0xFF adds none and 0x00 adds 255.
- R8: When the FIFO is empty at the end of a frame's last fill bit, the block goes idle at that cell boundary with no extra fill, and `tx_busy` never falls mid-cell.
- R9: A data write into an idle, empty block is seen as `fifo_empty`=0 and `tx_busy`=0 one clock after the write edge. The word is popped on the next edge, and `tx_busy` is 1 after it.
- R10: The FIFO holds 4 words. `fifo_full` is 1 with 4 words held, `fifo_empty` is 1 with none, and the two are never both 1.
- R11: A data write while `fifo_full` is 1 is dropped, even if a pop happens in the same cycle, and it sets `fifo_ovf`, which stays 1 until reset.
- R12: The address and parity select stay in force for every later frame until the control register is rewritten.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 4 | [2:0] station address, [3] parity select (1 = odd) |
| fill_wr | input | 1 | Fill register write strobe |
| fill_wdata | input | 8 | One's complement of the extra fill count |
| data_wr | input | 1 | Data byte write strobe, pushes one word |
| data_wdata | input | 8 | Data byte |
| tx_inv | input | 1 | Inverts the line output |
| tx_line | output | 1 | Biphase serial line |
| tx_busy | output | 1 | Serializer is sending sync, frame or gap |
| fifo_full | output | 1 | FIFO holds 4 words |
| fifo_empty | output | 1 | FIFO holds no word |
| fifo_ovf | output | 1 | Sticky flag, a write was dropped while full |

## Verification
Two things can fall on one edge: a host push and the serializer's pop. A control write can also coincide with a data write. The bench forces a push onto the pop edge by writing a second word just as the idle block takes the first. In a back-to-back burst, it drives writes into a full FIFO. It also issues a control write together with a data write. Each case is judged by the occupancy flags one clock later and by decoding the line bit by bit. The decoded stream must match a model frame list in which a dropped write is absent and the same-cycle word carries the old control fields.

// File: rtl/bft_pkg.sv
package bft_pkg;
   localparam int DATA_W     = 8;
   localparam int ADDR_W     = 3;
   localparam int FILL_TAIL  = 3;
   localparam int FRAME_BITS = 1 + DATA_W + ADDR_W + 1 + FILL_TAIL;

   typedef struct packed {
      logic              odd_par;
      logic [ADDR_W-1:0] addr;
      logic [DATA_W-1:0] data;
   } tx_word_t;

   localparam int WORD_W = $bits(tx_word_t);

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SEND = 2'd1,
      ST_GAP  = 2'd2
   } tx_state_e;
endpackage

// File: rtl/bft_ctl_regs.sv
module bft_ctl_regs
   import bft_pkg::*;
#(
   parameter int FILL_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ctl_wr,
   input  logic [ADDR_W:0]     ctl_wdata,
   input  logic                fill_wr,
   input  logic [FILL_W-1:0]   fill_wdata,
   input  logic [DATA_W-1:0]   data_wdata,
   output tx_word_t            word,
   output logic [FILL_W-1:0]   fill_q
);
   logic [ADDR_W:0] ctl_q;

   generate
      if (FILL_W < 1) begin : g_bad_fill
         $error("bft_ctl_regs: FILL_W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q  <= '0;
         fill_q <= '1;
      end else begin
         if (ctl_wr)  ctl_q  <= ctl_wdata;
         if (fill_wr) fill_q <= fill_wdata;
      end
   end

   // the word takes the register value from before this cycle's control write
   always_comb begin
      word.odd_par = ctl_q[ADDR_W];
      word.addr    = ctl_q[ADDR_W-1:0];
      word.data    = data_wdata;
   end
endmodule

// File: rtl/bft_fifo.sv
module bft_fifo #(
   parameter int WIDTH = 12,
   parameter int DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] wdata,
   input  logic             pop,
   output logic [WIDTH-1:0] rdata,
   output logic             full,
   output logic             empty,
   output logic             overflow
);
   localparam int  PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int  CNT_W   = $clog2(DEPTH + 1);
   localparam bit  IS_POW2 = (DEPTH & (DEPTH - 1)) == 0;

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CNT_W-1:0] count;
   logic             push_ok, pop_ok;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("bft_fifo: DEPTH must be at least 2");
      end
      if (IS_POW2) begin : g_wrap_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   assign full    = (count == CNT_W'(DEPTH));
   assign empty   = (count == '0);
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;
   assign rdata   = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr   <= '0;
         rd_ptr   <= '0;
         count    <= '0;
         overflow <= 1'b0;
      end else begin
         if (push_ok) wr_ptr <= wr_nxt;
         if (pop_ok)  rd_ptr <= rd_nxt;
         case ({push_ok, pop_ok})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
         if (push && full) overflow <= 1'b1;
      end
   end

   // R10
   full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(full && empty));
   // R10
   no_empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
   // R11
   drop_on_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop) |=> full);
   // R11
   overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow);
endmodule

// File: rtl/bft_serializer.sv
module bft_serializer
   import bft_pkg::*;
#(
   parameter int              HALF_CLKS = 4,
   parameter int              FILL_W    = 8,
   parameter int              SYNC_W    = 4,
   parameter logic [SYNC_W-1:0] SYNC_PAT = 4'b1110
) (
   input  logic              clk,
   input  logic              rst_n,
   input  tx_word_t          head,
   input  logic              fifo_empty,
   input  logic [FILL_W-1:0] fill_q,
   input  logic              inv,
   output logic              pop,
   output logic              busy,
   output logic              line
);
   localparam int HC_W      = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;
   localparam int LEN       = SYNC_W + FRAME_BITS;
   localparam int LEN_W     = $clog2(LEN);
   localparam int IDX_W     = (FILL_W > LEN_W) ? FILL_W : LEN_W;
   localparam int START_POS = FRAME_BITS - 1;
   localparam int ADDR_TOP  = START_POS - 1 - DATA_W;

   tx_state_e         state;
   logic [LEN-1:0]    sh_q;
   logic [IDX_W-1:0]  idx;
   logic [FILL_W-1:0] gap_len;
   logic [HC_W-1:0]   hcnt;
   logic              phase;

   logic [FRAME_BITS-1:0] frame_d;
   logic [FILL_W-1:0]     fill_n;
   logic cell_end, last_cell, gap_last, start_frame, cur_bit, enc;

   generate
      if (HALF_CLKS < 1) begin : g_bad_half
         $error("bft_serializer: HALF_CLKS must be at least 1");
      end
      if (SYNC_W < 1 || SYNC_W > 16) begin : g_bad_sync
         $error("bft_serializer: SYNC_W must be within 1..16");
      end
   endgenerate

   // frame image, most significant position sent first
   always_comb begin
      frame_d            = '0;
      frame_d[START_POS] = 1'b1;
      for (int i = 0; i < DATA_W; i++) frame_d[START_POS-1-i] = head.data[i];
      for (int j = 0; j < ADDR_W; j++) frame_d[ADDR_TOP-j]    = head.addr[j];
      frame_d[FILL_TAIL] = (^{1'b1, head.addr, head.data}) ^ head.odd_par;
   end

   assign fill_n    = ~fill_q;
   assign cell_end  = phase && (hcnt == HC_W'(HALF_CLKS - 1));
   assign last_cell = (idx == IDX_W'(LEN - 1));
   assign gap_last  = ((idx + 1'b1) == IDX_W'(gap_len));

   always_comb begin
      start_frame = 1'b0;
      if (state == ST_IDLE) begin
         start_frame = !fifo_empty;
      end else if (cell_end) begin
         if (state == ST_SEND && last_cell && !fifo_empty && fill_n == '0)
            start_frame = 1'b1;
         if (state == ST_GAP && gap_last)
            start_frame = !fifo_empty;
      end
   end

   assign pop     = start_frame;
   assign busy    = (state != ST_IDLE);
   assign cur_bit = (state == ST_SEND) ? sh_q[LEN-1] : 1'b0;
   assign enc     = phase ? cur_bit : ~cur_bit;
   assign line    = (busy ? enc : 1'b0) ^ inv;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         sh_q    <= '0;
         idx     <= '0;
         gap_len <= '0;
         hcnt    <= '0;
         phase   <= 1'b0;
      end else begin
         if (state != ST_IDLE) begin
            if (hcnt == HC_W'(HALF_CLKS - 1)) begin
               hcnt  <= '0;
               phase <= ~phase;
            end else begin
               hcnt <= hcnt + 1'b1;
            end
         end
         if (start_frame) begin
            state <= ST_SEND;
            sh_q  <= {SYNC_PAT, frame_d};
            idx   <= '0;
            hcnt  <= '0;
            phase <= 1'b0;
         end else if (cell_end) begin
            case (state)
               ST_SEND: begin
                  if (last_cell) begin
                     if (fifo_empty) begin
                        state <= ST_IDLE;
                     end else begin
                        state   <= ST_GAP;
                        gap_len <= fill_n;
                        idx     <= '0;
                     end
                  end else begin
                     idx  <= idx + 1'b1;
                     sh_q <= {sh_q[LEN-2:0], 1'b0};
                  end
               end
               ST_GAP: begin
                  if (gap_last) state <= ST_IDLE;
                  else          idx   <= idx + 1'b1;
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   // R5
   mid_cell_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !phase && hcnt == HC_W'(HALF_CLKS - 1)) |=> ((line ^ inv) != $past(line ^ inv)));
   // R9
   pop_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop |=> busy);
   // R8
   busy_holds_midcell_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !cell_end) |=> busy);
   // R7
   gap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_GAP) |-> ((line ^ inv) == !phase));
endmodule

// File: rtl/biph_frame_tx.sv
module biph_frame_tx
   import bft_pkg::*;
#(
   parameter int                HALF_CLKS  = 4,
   parameter int                FIFO_DEPTH = 4,
   parameter int                FILL_W     = 8,
   parameter int                SYNC_W     = 4,
   parameter logic [SYNC_W-1:0] SYNC_PAT   = 4'b1110
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr,
   input  logic [ADDR_W:0]   ctl_wdata,
   input  logic              fill_wr,
   input  logic [FILL_W-1:0] fill_wdata,
   input  logic              data_wr,
   input  logic [DATA_W-1:0] data_wdata,
   input  logic              tx_inv,
   output logic              tx_line,
   output logic              tx_busy,
   output logic              fifo_full,
   output logic              fifo_empty,
   output logic              fifo_ovf
);
   tx_word_t          wr_word, head_word;
   logic [WORD_W-1:0] head_bits;
   logic [FILL_W-1:0] fill_q;
   logic              pop;

   bft_ctl_regs #(.FILL_W(FILL_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctl_wr     (ctl_wr),
      .ctl_wdata  (ctl_wdata),
      .fill_wr    (fill_wr),
      .fill_wdata (fill_wdata),
      .data_wdata (data_wdata),
      .word       (wr_word),
      .fill_q     (fill_q)
   );

   bft_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (data_wr),
      .wdata    (wr_word),
      .pop      (pop),
      .rdata    (head_bits),
      .full     (fifo_full),
      .empty    (fifo_empty),
      .overflow (fifo_ovf)
   );

   assign head_word = tx_word_t'(head_bits);

   bft_serializer #(
      .HALF_CLKS (HALF_CLKS),
      .FILL_W    (FILL_W),
      .SYNC_W    (SYNC_W),
      .SYNC_PAT  (SYNC_PAT)
   ) u_ser (
      .clk        (clk),
      .rst_n      (rst_n),
      .head       (head_word),
      .fifo_empty (fifo_empty),
      .fill_q     (fill_q),
      .inv        (tx_inv),
      .pop        (pop),
      .busy       (tx_busy),
      .line       (tx_line)
   );
endmodule

// File: tb/biph_frame_tx_tb.sv
`timescale 1ns/1ps
module biph_frame_tx_tb;
   localparam int         HALF = 4;
   localparam logic [3:0] SYNC = 4'b1110;

   logic       clk = 1'b0, rst_n = 1'b0;
   logic       ctl_wr = 1'b0, fill_wr = 1'b0, data_wr = 1'b0, tx_inv = 1'b0;
   logic [3:0] ctl_wdata = '0;
   logic [7:0] fill_wdata = '0, data_wdata = '0;
   logic       tx_line, tx_busy, fifo_full, fifo_empty, fifo_ovf;

   always #2.5 clk = ~clk;

   biph_frame_tx #(.HALF_CLKS(HALF)) u_dut (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
      .fill_wr(fill_wr), .fill_wdata(fill_wdata), .data_wr(data_wr),
      .data_wdata(data_wdata), .tx_inv(tx_inv), .tx_line(tx_line),
      .tx_busy(tx_busy), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
      .fifo_ovf(fifo_ovf)
   );

   int   n_tests = 0, n_fail = 0;
   bit   done = 1'b0;
   bit   cells[$];
   int   mid_err = 0, idle_err = 0;
   bit   mon_active = 1'b0;
   logic [11:0] exp_q[$];
   logic [3:0]  m_ctl = '0;
   logic [7:0]  m_fill = 8'hFF;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   // line monitor: one sample per half cell, decoded to bits
   initial begin
      int  k;
      bit  first;
      forever begin
         @(negedge clk);
         if (tx_busy) begin
            mon_active = 1'b1;
            k = 0;
            while (tx_busy) begin
               if (k % HALF == 0) begin
                  if (((k / HALF) % 2) == 0) first = tx_line;
                  else begin
                     if (first == tx_line) mid_err++;
                     cells.push_back(tx_line ^ tx_inv);
                  end
               end
               k++;
               @(negedge clk);
            end
            if (tx_line !== tx_inv) idle_err++;
            mon_active = 1'b0;
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      finish_run();
   end

   // all driving tasks start right after a negative edge
   task automatic push_word(input logic [7:0] d, input bit with_ctl, input logic [3:0] c);
      data_wr = 1'b1; data_wdata = d; ctl_wr = with_ctl; ctl_wdata = c;
      if (!fifo_full) exp_q.push_back({m_ctl, d});
      if (with_ctl) m_ctl = c;
      @(negedge clk);
      data_wr = 1'b0; ctl_wr = 1'b0;
   endtask

   task automatic set_ctl(input logic [3:0] c);
      ctl_wr = 1'b1; ctl_wdata = c; m_ctl = c;
      @(negedge clk);
      ctl_wr = 1'b0;
   endtask

   task automatic set_fill(input logic [7:0] f);
      fill_wr = 1'b1; fill_wdata = f; m_fill = f;
      @(negedge clk);
      fill_wr = 1'b0;
   endtask

   task automatic wait_idle();
      int t;
      t = 0;
      repeat (3) @(negedge clk);
      while ((tx_busy || !fifo_empty || mon_active) && t < 20000) begin
         @(negedge clk);
         t++;
      end
      @(negedge clk);
   endtask

   task automatic check_msg(input string tag);
      bit eb[$];
      int par_pos[$];
      bit par_exp[$];
      int gap, mis, first_bad;
      gap = int'(8'(~m_fill));
      for (int i = 0; i < exp_q.size(); i++) begin
         logic [11:0] w;
         bit p;
         w = exp_q[i];
         for (int s = 3; s >= 0; s--) eb.push_back(SYNC[s]);
         eb.push_back(1'b1);
         for (int b = 0; b < 8; b++) eb.push_back(w[b]);
         for (int a = 0; a < 3; a++) eb.push_back(w[8 + a]);
         p = (^{1'b1, w[10:0]}) ^ w[11];
         par_pos.push_back(eb.size());
         par_exp.push_back(p);
         eb.push_back(p);
         repeat (3) eb.push_back(1'b0);
         if (i < exp_q.size() - 1) repeat (gap) eb.push_back(1'b0);
      end
      // R8 no trailing fill after the last frame, R7 gap length
      chk(cells.size() == eb.size(), {tag, " R7 R8 cell count"}, cells.size(), eb.size());
      mis = 0; first_bad = -1;
      for (int i = 0; i < eb.size() && i < cells.size(); i++)
         if (cells[i] != eb[i]) begin
            mis++;
            if (first_bad < 0) first_bad = i;
         end
      chk(mis == 0, {tag, " R3 bit stream mismatches"}, mis, 0);
      for (int f = 0; f < par_pos.size(); f++)
         if (par_pos[f] < cells.size())
            chk(cells[par_pos[f]] == par_exp[f], {tag, " R4 parity bit"}, cells[par_pos[f]], par_exp[f]);
      chk(mid_err == 0, {tag, " R5 mid-cell transition"}, mid_err, 0);
      chk(idle_err == 0, {tag, " R6 R8 idle level after message"}, idle_err, 0);
      cells.delete(); exp_q.delete();
      mid_err = 0; idle_err = 0;
   endtask

   initial begin
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(!tx_busy,   "R1 busy after reset", tx_busy, 0);
      chk(fifo_empty, "R1 empty after reset", fifo_empty, 1);
      chk(!fifo_full, "R1 full after reset", fifo_full, 0);
      chk(!fifo_ovf,  "R1 overflow after reset", fifo_ovf, 0);
      chk(tx_line == 1'b0, "R1 idle line after reset", tx_line, 0);

      // R9 start latency, R12 control persistence, R1 default fill
      set_ctl(4'b0101);
      push_word(8'hA5, 1'b0, 4'h0);
      chk(!tx_busy && !fifo_empty, "R9 word queued, not yet started", {tx_busy, fifo_empty}, 2'b00);
      push_word(8'h3C, 1'b0, 4'h0);
      chk(tx_busy, "R9 busy after pop", tx_busy, 1);
      chk(!fifo_empty, "R9 push and pop same edge keep one word", fifo_empty, 0);
      push_word(8'h00, 1'b0, 4'h0);
      wait_idle();
      check_msg("R12 R1");

      // R2 control write in the same cycle as a data write
      set_ctl(4'b1010);
      push_word(8'h11, 1'b0, 4'h0);
      push_word(8'h22, 1'b1, 4'b0011);
      push_word(8'h33, 1'b0, 4'h0);
      wait_idle();
      check_msg("R2");

      // R7 extra fill: 3 cells, then 255 cells
      set_fill(8'hFC);
      push_word(8'h5A, 1'b0, 4'h0);
      push_word(8'hC3, 1'b1, 4'b1111);
      push_word(8'h81, 1'b0, 4'h0);
      wait_idle();
      check_msg("R7 gap3");
      set_fill(8'h00);
      push_word(8'hFF, 1'b0, 4'h0);
      push_word(8'h01, 1'b0, 4'h0);
      wait_idle();
      check_msg("R7 gap255");
      set_fill(8'hFF);

      // R6 inverted line
      tx_inv = 1'b1;
      @(negedge clk);
      chk(tx_line == 1'b1, "R6 inverted idle level", tx_line, 1);
      push_word(8'h96, 1'b1, 4'b1100);
      push_word(8'h69, 1'b0, 4'h0);
      wait_idle();
      check_msg("R6");
      tx_inv = 1'b0;
      @(negedge clk);

      // R10 R11 burst into a full FIFO
      push_word(8'h10, 1'b0, 4'h0);
      push_word(8'h20, 1'b0, 4'h0);
      push_word(8'h30, 1'b0, 4'h0);
      push_word(8'h40, 1'b0, 4'h0);
      push_word(8'h50, 1'b0, 4'h0);
      chk(fifo_full, "R10 full with 4 words", fifo_full, 1);
      chk(!fifo_ovf, "R11 no overflow before a dropped write", fifo_ovf, 0);
      push_word(8'h60, 1'b0, 4'h0);
      chk(fifo_ovf, "R11 overflow set by dropped write", fifo_ovf, 1);
      chk(fifo_full, "R11 dropped write leaves occupancy", fifo_full, 1);
      wait_idle();
      check_msg("R11 burst");
      chk(fifo_ovf, "R11 overflow sticky", fifo_ovf, 1);
      chk(fifo_empty && !fifo_full, "R10 empty after message", {fifo_full, fifo_empty}, 2'b01);

      // constrained random messages
      for (int m = 0; m < 14; m++) begin
         int nfr;
         tx_inv = 1'($urandom % 2);
         set_fill(8'(~($urandom % 5)));
         if ($urandom % 2 == 1) set_ctl(4'($urandom));
         nfr = 1 + int'($urandom % 6);
         for (int f = 0; f < nfr; f++) begin
            while (fifo_full) @(negedge clk);
            repeat ($urandom % 3) @(negedge clk);
            push_word(8'($urandom), ($urandom % 3) == 0, 4'($urandom));
         end
         wait_idle();
         check_msg("random R2 R3 R12");
      end

      finish_run();
   end
endmodule